// File: doc/BRIEF.md
# Hue-Saturation 2D Histogram Generator

This block watches a stream of 32-bit colour pixels, each made of 8-bit alpha, hue, saturation and value fields. For every pixel that lands inside a programmable crop rectangle and survives an optional per-axis subsampling pattern, it finds the hue area the pixel belongs to. It then adds one to a counter in a matrix of hue areas by saturation bins. Alongside the matrix it keeps the smallest and largest saturation seen and a running saturation total.

Software sets the crop rectangle, the subsampling codes and six lower/upper hue boundary pairs. It pulses `clear` before each frame and streams the frame in, marking the first pixel, each line end and the last pixel. After the last pixel the results freeze and can be read one word per cycle through a small read port. The stream input is valid/ready: a pixel moves when `pix_valid` and `pix_ready` are both high. `pix_ready` drops only in a cycle where `clear` is asserted, so a source must hold its pixel until ready returns. No other back-pressure exists.

Top module: `hsv_hist2d`

## Requirements
- R1: `pix_data` carries alpha in [31:24], hue in [23:16], saturation in [15:8] and value in [7:0]. `pix_ready` is high in every cycle except one where `clear` is high, and a pixel is taken only when `pix_valid` and `pix_ready` are both high.
- R2: Pixel positions count from (0,0) at the pixel flagged `pix_sof`. The column advances per taken pixel and the row advances after a pixel flagged `pix_eol`. Only pixels with `crop_hoff <= x < crop_hoff+crop_hsize` and `crop_voff <= y < crop_voff+crop_vsize` are counted.
- R3: Per axis, with the offset d from the crop origin, ratio code 0 counts every pixel, code 1 counts pixels with d a multiple of 2, and codes 2 and 3 count pixels with d a multiple of 4.
- R4: Area i (bounds at bits [8i+7:8i] of `hue_lo`/`hue_hi`) matches when lo ≤ hue ≤ hi. When lo > hi, area 0 matches hue ≥ lo or hue ≤ hi, and any other area matches nothing. A counted pixel matching no area adds to no bin.
- R5: When several areas match, only the lowest-numbered one is incremented.
- R6: The saturation bin is saturation[7:3]. The counter for area a, bin b is read at address 2 + 32·a + b.
- R7: Address 0 reads the maximum counted saturation in bits [23:16] and the minimum in [7:0], with other bits zero. After reset or clear the maximum is 0 and the minimum is 255.
- R8: Address 1 reads the sum of the saturation of all counted pixels (matching an area or not), which stops at all-ones instead of wrapping.
- R9: Each bin counter adds at most one per pixel and holds at all-ones instead of wrapping.
- R10: After a taken pixel flagged `pix_eof`, further pixels are taken but change no result until the next clear.
- R11: `clear` zeroes every bin and the sum, restores the R7 reset extremes, and re-enables counting. A pixel offered in the clear cycle is not taken.
- R12: `rd_data` shows the word for the `rd_addr` of the previous cycle, and addresses beyond 193 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Result clear pulse |
| pix_valid | input | 1 | Pixel offered |
| pix_ready | output | 1 | Pixel can be taken |
| pix_data | input | 32 | Alpha, hue, saturation, value |
| pix_sof | input | 1 | First pixel of frame |
| pix_eol | input | 1 | Last pixel of a line |
| pix_eof | input | 1 | Last pixel of frame |
| crop_hoff | input | COORD_W | Crop left column |
| crop_voff | input | COORD_W | Crop top row |
| crop_hsize | input | COORD_W | Crop width |
| crop_vsize | input | COORD_W | Crop height |
| hue_lo | input | 8·AREAS | Lower hue bound per area |
| hue_hi | input | 8·AREAS | Upper hue bound per area |
| sub_hratio | input | 2 | Horizontal subsampling code |
| sub_vratio | input | 2 | Vertical subsampling code |
| rd_addr | input | RAW (8) | Result word address |
| rd_data | output | 32 | Result word |

## Verification
Clearing and pixel intake can collide in one cycle. The bench raises `clear` while offering a pixel that falls inside the crop window and matches an area. It checks that `pix_ready` is low in that cycle and that every result word then reads back at its cleared value, with the offered pixel absent. End-of-frame freezing and later pixels also share cycles. The bench streams a whole second frame after `pix_eof` without clearing and requires all 194 words to be unchanged. The crop and subsampling sweep covers all sixteen ratio pairs against a model computed in the bench.

// File: rtl/hsvh_pkg.sv
package hsvh_pkg;

  typedef struct packed {
    logic [7:0] alpha;
    logic [7:0] hue;
    logic [7:0] sat;
    logic [7:0] val;
  } hsv_pix_t;

  // low-order offset bits that must be zero for a pixel to be kept
  function automatic logic [1:0] phase_mask(input logic [1:0] code);
    case (code)
      2'd0:    return 2'b00;
      2'd1:    return 2'b01;
      default: return 2'b11;
    endcase
  endfunction

endpackage

// File: rtl/hsvh_window_gate.sv
module hsvh_window_gate
  import hsvh_pkg::*;
#(
  parameter int COORD_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               step,
  input  logic               sof,
  input  logic               eol,
  input  logic [COORD_W-1:0] hoff,
  input  logic [COORD_W-1:0] voff,
  input  logic [COORD_W-1:0] hsize,
  input  logic [COORD_W-1:0] vsize,
  input  logic [1:0]         hratio,
  input  logic [1:0]         vratio,
  output logic               take
);

  logic [COORD_W-1:0] x_q, y_q;
  logic [COORD_W-1:0] cur_x, cur_y;
  logic [COORD_W-1:0] dx, dy;
  logic               in_x, in_y, ph_x, ph_y;

  always_comb begin
    cur_x = sof ? '0 : x_q;
    cur_y = sof ? '0 : y_q;
    dx    = cur_x - hoff;
    dy    = cur_y - voff;
    in_x  = (cur_x >= hoff) && (dx < hsize);
    in_y  = (cur_y >= voff) && (dy < vsize);
    ph_x  = (dx[1:0] & phase_mask(hratio)) == 2'b00;
    ph_y  = (dy[1:0] & phase_mask(vratio)) == 2'b00;
    take  = in_x && in_y && ph_x && ph_y;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      x_q <= '0;
      y_q <= '0;
    end else if (step) begin
      if (eol) begin
        x_q <= '0;
        y_q <= cur_y + 1'b1;
      end else begin
        x_q <= cur_x + 1'b1;
        y_q <= cur_y;
      end
    end
  end

  // R2: a taken pixel that ends no line moves the column on by exactly one
  p_col_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear && !eol) |=> (x_q == COORD_W'($past(cur_x) + 1'b1)));

  // R2: a line end returns the column to zero
  p_line_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear && eol) |=> (x_q == '0));

endmodule

// File: rtl/hsvh_hue_classifier.sv
module hsvh_hue_classifier #(
  parameter  int AREAS = 6,
  localparam int AW    = (AREAS > 1) ? $clog2(AREAS) : 1
) (
  input  logic [7:0]         hue,
  input  logic [AREAS*8-1:0] lo_bus,
  input  logic [AREAS*8-1:0] hi_bus,
  output logic               hit,
  output logic [AW-1:0]      area
);

  logic [AREAS-1:0] match;

  for (genvar i = 0; i < AREAS; i++) begin : g_area
    logic [7:0] lo, hi;
    assign lo = lo_bus[i*8 +: 8];
    assign hi = hi_bus[i*8 +: 8];
    if (i == 0) begin : g_wrap
      assign match[i] = (lo <= hi) ? (hue >= lo && hue <= hi)
                                   : (hue >= lo || hue <= hi);
    end else begin : g_plain
      assign match[i] = (hue >= lo) && (hue <= hi);
    end
  end

  // lowest-numbered matching area wins
  always_comb begin
    hit  = 1'b0;
    area = '0;
    for (int i = AREAS - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit  = 1'b1;
        area = AW'(i);
      end
    end
  end

endmodule

// File: rtl/hsvh_bin_matrix.sv
module hsvh_bin_matrix #(
  parameter  int AREAS = 6,
  parameter  int SBINS = 32,
  parameter  int CNT_W = 32,
  localparam int AW    = (AREAS > 1) ? $clog2(AREAS) : 1,
  localparam int BW    = $clog2(SBINS),
  localparam int NCELL = AREAS * SBINS,
  localparam int IW    = $clog2(NCELL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [AW-1:0]    area,
  input  logic [BW-1:0]    bin,
  input  logic [IW-1:0]    rd_idx,
  output logic [CNT_W-1:0] rd_cnt
);

  logic [CNT_W-1:0] cnt_q [NCELL];
  logic [IW-1:0]    wr_idx;

  assign wr_idx = IW'(int'(area) * SBINS + int'(bin));

  for (genvar c = 0; c < NCELL; c++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n || clr)
        cnt_q[c] <= '0;
      else if (inc && wr_idx == IW'(c) && cnt_q[c] != '1)
        cnt_q[c] <= cnt_q[c] + 1'b1;
    end

    // R9: a counter moves by at most one per cycle
    p_bin_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (cnt_q[c] == $past(cnt_q[c]) || cnt_q[c] == $past(cnt_q[c]) + 1'b1));

    // R9: a full counter stays full until cleared
    p_bin_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q[c] == '1 && !clr) |=> (cnt_q[c] == '1));
  end

  always_comb begin
    rd_cnt = '0;
    if (32'(rd_idx) < NCELL)
      rd_cnt = cnt_q[rd_idx];
  end

endmodule

// File: rtl/hsv_hist2d.sv
module hsv_hist2d
  import hsvh_pkg::*;
#(
  parameter  int AREAS   = 6,
  parameter  int SBINS   = 32,
  parameter  int CNT_W   = 32,
  parameter  int SUM_W   = 32,
  parameter  int COORD_W = 12,
  localparam int NCELL   = AREAS * SBINS,
  localparam int RAW     = $clog2(NCELL + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               pix_valid,
  output logic               pix_ready,
  input  logic [31:0]        pix_data,
  input  logic               pix_sof,
  input  logic               pix_eol,
  input  logic               pix_eof,
  input  logic [COORD_W-1:0] crop_hoff,
  input  logic [COORD_W-1:0] crop_voff,
  input  logic [COORD_W-1:0] crop_hsize,
  input  logic [COORD_W-1:0] crop_vsize,
  input  logic [AREAS*8-1:0] hue_lo,
  input  logic [AREAS*8-1:0] hue_hi,
  input  logic [1:0]         sub_hratio,
  input  logic [1:0]         sub_vratio,
  input  logic [RAW-1:0]     rd_addr,
  output logic [31:0]        rd_data
);

  localparam int AW = (AREAS > 1) ? $clog2(AREAS) : 1;
  localparam int BW = $clog2(SBINS);
  localparam int IW = $clog2(NCELL);

  hsv_pix_t          px;
  logic              accept, take, count_en, hit;
  logic [AW-1:0]     area;
  logic [BW-1:0]     bin;
  logic [IW-1:0]     rd_idx;
  logic [CNT_W-1:0]  rd_cnt;
  logic              frozen_q;
  logic [7:0]        max_q, min_q;
  logic [SUM_W-1:0]  sum_q;
  logic [SUM_W:0]    sum_ext;

  assign px        = hsv_pix_t'(pix_data);
  assign pix_ready = ~clear;
  assign accept    = pix_valid & pix_ready;
  assign count_en  = accept & take & ~frozen_q;
  assign bin       = px.sat[7 -: BW];
  assign sum_ext   = {1'b0, sum_q} + (SUM_W + 1)'(px.sat);
  assign rd_idx    = IW'(rd_addr - RAW'(2));

  hsvh_window_gate #(.COORD_W(COORD_W)) u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (clear),
    .step   (accept),
    .sof    (pix_sof),
    .eol    (pix_eol),
    .hoff   (crop_hoff),
    .voff   (crop_voff),
    .hsize  (crop_hsize),
    .vsize  (crop_vsize),
    .hratio (sub_hratio),
    .vratio (sub_vratio),
    .take   (take)
  );

  hsvh_hue_classifier #(.AREAS(AREAS)) u_hue (
    .hue    (px.hue),
    .lo_bus (hue_lo),
    .hi_bus (hue_hi),
    .hit    (hit),
    .area   (area)
  );

  hsvh_bin_matrix #(.AREAS(AREAS), .SBINS(SBINS), .CNT_W(CNT_W)) u_bins (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clear),
    .inc    (count_en & hit),
    .area   (area),
    .bin    (bin),
    .rd_idx (rd_idx),
    .rd_cnt (rd_cnt)
  );

  // summary statistics and frame-end freeze
  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      frozen_q <= 1'b0;
      max_q    <= 8'h00;
      min_q    <= 8'hFF;
      sum_q    <= '0;
    end else begin
      if (accept && pix_eof)
        frozen_q <= 1'b1;
      if (count_en) begin
        if (px.sat > max_q) max_q <= px.sat;
        if (px.sat < min_q) min_q <= px.sat;
        sum_q <= sum_ext[SUM_W] ? '1 : sum_ext[SUM_W-1:0];
      end
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (!rst_n)
      rd_data <= '0;
    else if (rd_addr == RAW'(0))
      rd_data <= {8'h00, max_q, 8'h00, min_q};
    else if (rd_addr == RAW'(1))
      rd_data <= 32'(sum_q);
    else if (32'(rd_addr) < NCELL + 2)
      rd_data <= 32'(rd_cnt);
    else
      rd_data <= '0;
  end

  // R11: clear restores the summary reset values
  p_clear_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (sum_q == '0 && max_q == 8'h00 && min_q == 8'hFF));

  // R10: frozen results do not move until a clear
  p_frozen_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen_q && !clear) |=> ($stable(sum_q) && $stable(max_q) && $stable(min_q)));

  // R8: the running sum never decreases between clears
  p_sum_nondec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (sum_q >= $past(sum_q)));

  // R7: once a non-zero saturation was counted the extremes are ordered
  p_extreme_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_q != '0) |-> (max_q >= min_q));

endmodule

// File: tb/hsv_hist2d_test.sv
`timescale 1ns/1ps
module hsv_hist2d_test;

  localparam int W = 10;
  localparam int H = 6;
  localparam int CMAX = 15;
  localparam int SMAX = 4095;

  logic        clk = 1'b0;
  logic        rst_n, clear, pix_valid, pix_ready, pix_sof, pix_eol, pix_eof;
  logic [31:0] pix_data, rd_data;
  logic [7:0]  crop_hoff, crop_voff, crop_hsize, crop_vsize;
  logic [47:0] hue_lo, hue_hi;
  logic [1:0]  sub_hratio, sub_vratio;
  logic [7:0]  rd_addr;

  always #2 clk = ~clk;

  hsv_hist2d #(.AREAS(6), .SBINS(32), .CNT_W(4), .SUM_W(12), .COORD_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .pix_valid(pix_valid),
    .pix_ready(pix_ready), .pix_data(pix_data), .pix_sof(pix_sof),
    .pix_eol(pix_eol), .pix_eof(pix_eof), .crop_hoff(crop_hoff),
    .crop_voff(crop_voff), .crop_hsize(crop_hsize), .crop_vsize(crop_vsize),
    .hue_lo(hue_lo), .hue_hi(hue_hi), .sub_hratio(sub_hratio),
    .sub_vratio(sub_vratio), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int n_chk = 0, n_fail = 0;
  int lo_m[6], hi_m[6];
  int eb[6][32];
  int esum, emax, emin;
  bit efrz;
  int hoff, voff, hsz, vsz, hr, vr;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int a = 0; a < 6; a++)
      for (int b = 0; b < 32; b++) eb[a][b] = 0;
    esum = 0; emax = 0; emin = 255; efrz = 0;
  endtask

  task automatic set_hues(input bit wrap_cfg);
    if (!wrap_cfg) begin
      lo_m = '{0, 30, 81, 121, 201, 10};
      hi_m = '{40, 80, 120, 200, 250, 5};
    end else begin
      lo_m = '{240, 21, 61, 101, 151, 201};
      hi_m = '{20, 60, 100, 150, 200, 239};
    end
    for (int i = 0; i < 6; i++) begin
      hue_lo[i*8 +: 8] = 8'(lo_m[i]);
      hue_hi[i*8 +: 8] = 8'(hi_m[i]);
    end
  endtask

  task automatic set_crop(input int ho, input int hs, input int vo, input int vs,
                          input int rh, input int rv);
    hoff = ho; hsz = hs; voff = vo; vsz = vs; hr = rh; vr = rv;
    crop_hoff = 8'(ho); crop_hsize = 8'(hs);
    crop_voff = 8'(vo); crop_vsize = 8'(vs);
    sub_hratio = 2'(rh); sub_vratio = 2'(rv);
  endtask

  function automatic int area_of(input int h);
    for (int i = 0; i < 6; i++) begin
      if (lo_m[i] <= hi_m[i]) begin
        if (h >= lo_m[i] && h <= hi_m[i]) return i;
      end else if (i == 0) begin
        if (h >= lo_m[i] || h <= hi_m[i]) return i;
      end
    end
    return -1;
  endfunction

  function automatic int stride(input int code);
    return (code == 0) ? 1 : (code == 1) ? 2 : 4;
  endfunction

  task automatic send_pix(input int x, input int y, input bit sof, input bit eol,
                          input bit eof, input int h, input int s);
    int ar;
    @(negedge clk);
    pix_valid = 1'b1; pix_sof = sof; pix_eol = eol; pix_eof = eof;
    pix_data = {8'hA5, 8'(h), 8'(s), 8'h3C};
    if (!efrz && x >= hoff && x < hoff + hsz && y >= voff && y < voff + vsz &&
        (x - hoff) % stride(hr) == 0 && (y - voff) % stride(vr) == 0) begin
      esum = (esum + s > SMAX) ? SMAX : esum + s;
      if (s > emax) emax = s;
      if (s < emin) emin = s;
      ar = area_of(h);
      if (ar >= 0 && eb[ar][s/8] < CMAX) eb[ar][s/8]++;
    end
    if (eof) efrz = 1;
    @(posedge clk);
  endtask

  task automatic idle_stream();
    @(negedge clk);
    pix_valid = 1'b0; pix_sof = 1'b0; pix_eol = 1'b0; pix_eof = 1'b0;
  endtask

  task automatic send_frame(input int f);
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++)
        send_pix(x, y, (x == 0 && y == 0), (x == W - 1), (x == W - 1 && y == H - 1),
                 (x * 37 + y * 71 + f * 13) % 256, (x * 29 + y * 53 + f * 7) % 256);
    idle_stream();
  endtask

  // R11: clear with a countable pixel offered in the same cycle
  task automatic do_clear();
    @(negedge clk);
    clear = 1'b1; pix_valid = 1'b1; pix_sof = 1'b1;
    pix_data = {8'h00, 8'd50, 8'd200, 8'd0};
    #1 check("R11 ready low while clearing", int'(pix_ready), 0);
    @(posedge clk);
    @(negedge clk);
    clear = 1'b0; pix_valid = 1'b0; pix_sof = 1'b0;
    model_reset();
  endtask

  task automatic read_word(input int a, output int v);
    @(negedge clk);
    rd_addr = 8'(a);
    @(posedge clk);
    @(negedge clk);
    v = int'(rd_data);
  endtask

  task automatic read_all(input string tag);
    int v, e;
    for (int a = 0; a < 194; a++) begin
      read_word(a, v);
      if (a == 0)      e = (emax << 16) | emin;
      else if (a == 1) e = esum;
      else             e = eb[(a - 2) / 32][(a - 2) % 32];
      check($sformatf("%s addr %0d", tag, a), v, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int v;
    rst_n = 1'b0; clear = 1'b0; pix_valid = 1'b0; pix_sof = 1'b0;
    pix_eol = 1'b0; pix_eof = 1'b0; pix_data = '0; rd_addr = '0;
    set_hues(1'b0);
    set_crop(1, 7, 1, 4, 0, 0);
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R7 reset extremes, all bins empty
    read_all("R7 R11 reset state");
    read_word(194, v);
    check("R12 out-of-range address", v, 0);
    #1 check("R1 ready high when idle", int'(pix_ready), 1);

    // R2 R3 R4 R5 R6 sweep over every ratio pair, crop shape and hue set
    for (int rh = 0; rh < 4; rh++) begin
      for (int rv = 0; rv < 4; rv++) begin
        int f = rh * 4 + rv;
        set_hues(f % 2 == 1);
        case (f % 3)
          0: set_crop(1, 7, 1, 4, rh, rv);
          1: set_crop(2, 8, 0, 6, rh, rv);
          default: set_crop(0, 10, 2, 3, rh, rv);
        endcase
        do_clear();
        send_frame(f);
        read_all($sformatf("R2 R3 R4 R5 R6 R8 sweep h%0d v%0d", rh, rv));
      end
    end

    // R10 frame after eof without clear leaves every word unchanged
    send_frame(99);
    read_all("R10 frozen results");

    // R8 R9 saturation of sum and a bin
    set_hues(1'b0);
    set_crop(0, 10, 0, 6, 0, 0);
    do_clear();
    for (int i = 0; i < 20; i++)
      send_pix(i % 10, i / 10, i == 0, (i % 10) == 9, i == 19, 50, 255);
    idle_stream();
    read_all("R8 R9 saturation");

    // R11 clear after saturation
    do_clear();
    read_all("R11 after clear");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule